// File: doc/BRIEF.md
# Indirect VLAN Membership Table

This block keeps a small VLAN membership table that the host cannot address directly. The host reaches it through a window of byte-wide registers on a request/response register bus. It first writes an operation code into a command register. It then writes the entry number into an index register, and that second write starts the operation. A fetch copies the selected entry into three staging registers, where the host can read it byte by byte. A store moves the staging registers into the selected entry.

Each entry packs 22 bits: a 12-bit VLAN identifier, a 4-bit filter identifier, a 5-bit port mask and a valid flag. The three staging registers split this word. A single global bit selects 802.1Q tagged operation (set) or port-based operation (clear), and that bit drives the `vlan_en` pin. The block does not forward frames.

Bus rules: a request is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` falls for exactly one cycle, the one after an accepted index write, while the table operation runs. The host must keep the request stable while `req_ready` is low. A read response appears on `rsp_valid`/`rsp_rdata` in the cycle after the read is accepted and lasts one cycle. The response has no back-pressure.

Top module: `vlan_ind_table`

## Requirements
- R1: After reset, every entry reads back as all zeros (invalid), the staging registers read zero and `vlan_en` is low.
- R2: A write to address 0x05 sets `vlan_en` to bit 7 of the written byte. A read of 0x05 returns that bit in position 7, with zeros in all other bits.
- R3: Writing the index register 0x6F while the command register 0x6E holds 0x04 stores the staging word into the entry selected by the index.
- R4: Writing 0x6F while 0x6E holds 0x14 loads the selected entry into the staging registers. The three staging registers are laid out as follows:
  - 0x76 holds {2'b0, valid, ports[4:0]}.
  - 0x77 holds {fid[3:0], vid[11:8]}.
  - 0x78 holds vid[7:0].
  A read of 0x76 issued immediately afterwards returns the new data.
- R5: A store taken with all staging bits zero clears the entry, so that it reads back with the valid bit (bit 5 of 0x76) low.
- R6: An index value of 16 or more starts no operation. Neither the table nor the staging registers change.
- R7: A command code other than 0x14 or 0x04 makes an index write start no operation.
- R8: The host can write and read back the staging registers at any time without changing any table entry. Writes to 0x76 keep only bits 5:0.
- R9: `req_ready` is low exactly in the cycle after an accepted index write. `rsp_valid` is high exactly in the cycle after each accepted read.
- R10: Reads of addresses outside {0x05, 0x6E, 0x6F, 0x76, 0x77, 0x78} return 0. Writes to those addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Register address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle) |
| rsp_rdata | output | 8 | Read data |
| vlan_en | output | 1 | 802.1Q mode enable |

## Verification
The hardest situations to reach from the ports are two. The first is an index write whose value is 16 to 19: a truncating design would alias it onto entries 0 to 3. The second is a command register that holds an unknown code at the moment the index is written. Random stimulus picks indices from 0 to 19 and command bytes that include arbitrary values. Directed steps also place an out-of-range store right after entry 0 was left empty, then read entry 0 back. Every fetch is followed at once by a staging read, so each such read has to wait through the stall cycle.

// File: rtl/vlan_ind_pkg.sv
package vlan_ind_pkg;

  localparam int BYTE_W = 8;

  // host register map
  localparam logic [7:0] A_GLOBAL = 8'h05;
  localparam logic [7:0] A_CMD    = 8'h6E;
  localparam logic [7:0] A_INDEX  = 8'h6F;
  localparam logic [7:0] A_STG_HI = 8'h76;
  localparam logic [7:0] A_STG_MD = 8'h77;
  localparam logic [7:0] A_STG_LO = 8'h78;

  // command codes
  localparam logic [7:0] CMD_FETCH = 8'h14;
  localparam logic [7:0] CMD_STORE = 8'h04;

  localparam int GLB_EN_BIT = 7;

  typedef struct packed {
    logic       valid;
    logic [4:0] ports;
    logic [3:0] fid;
    logic [11:0] vid;
  } vent_t;

  localparam int ENTRY_W = $bits(vent_t);
  localparam int HI_W    = ENTRY_W - 2 * BYTE_W;

  function automatic logic is_mapped(input logic [7:0] a);
    return (a == A_GLOBAL) || (a == A_CMD) || (a == A_INDEX) ||
           (a == A_STG_HI) || (a == A_STG_MD) || (a == A_STG_LO);
  endfunction

endpackage

// File: rtl/vlan_ind_regs.sv
module vlan_ind_regs
  import vlan_ind_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [7:0]  req_addr,
  input  logic [7:0]  req_wdata,
  output logic        rsp_valid,
  output logic [7:0]  rsp_rdata,
  output logic        vlan_en,
  input  logic        busy,
  output logic        launch,
  output logic [7:0]  launch_cmd,
  output logic [7:0]  launch_idx,
  input  logic        load_go,
  input  vent_t       load_entry,
  output vent_t       stage
);

  logic       en_q;
  logic [7:0] cmd_q;
  logic [7:0] idx_q;
  vent_t      stage_q;
  logic       rsp_v_q;
  logic [7:0] rsp_d_q;
  logic       take;
  logic       take_wr;
  logic [7:0] rd_mux;

  assign take    = req_valid && !busy;
  assign take_wr = take && req_write;

  assign launch     = take_wr && (req_addr == A_INDEX);
  assign launch_cmd = cmd_q;
  assign launch_idx = req_wdata;

  always_comb begin
    rd_mux = '0;
    case (req_addr)
      A_GLOBAL: rd_mux[GLB_EN_BIT] = en_q;
      A_CMD:    rd_mux = cmd_q;
      A_INDEX:  rd_mux = idx_q;
      A_STG_HI: rd_mux = {{(BYTE_W - HI_W){1'b0}}, stage_q[ENTRY_W-1 -: HI_W]};
      A_STG_MD: rd_mux = stage_q[2*BYTE_W-1 -: BYTE_W];
      A_STG_LO: rd_mux = stage_q[BYTE_W-1:0];
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      cmd_q <= '0;
      idx_q <= '0;
    end else if (take_wr) begin
      case (req_addr)
        A_GLOBAL: en_q  <= req_wdata[GLB_EN_BIT];
        A_CMD:    cmd_q <= req_wdata;
        A_INDEX:  idx_q <= req_wdata;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else if (load_go) begin
      stage_q <= load_entry;
    end else if (take_wr) begin
      case (req_addr)
        A_STG_HI: stage_q[ENTRY_W-1 -: HI_W]     <= req_wdata[HI_W-1:0];
        A_STG_MD: stage_q[2*BYTE_W-1 -: BYTE_W]  <= req_wdata;
        A_STG_LO: stage_q[BYTE_W-1:0]            <= req_wdata;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_v_q <= 1'b0;
      rsp_d_q <= '0;
    end else begin
      rsp_v_q <= take && !req_write;
      if (take && !req_write) rsp_d_q <= rd_mux;
    end
  end

  assign req_ready = !busy;
  assign rsp_valid = rsp_v_q;
  assign rsp_rdata = rsp_d_q;
  assign vlan_en   = en_q;
  assign stage     = stage_q;

endmodule

// File: rtl/vlan_ind_seq.sv
module vlan_ind_seq
  import vlan_ind_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDXW = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            launch,
  input  logic [7:0]      launch_cmd,
  input  logic [7:0]      launch_idx,
  output logic            busy,
  output logic [IDXW-1:0] tab_idx,
  output logic            fetch_go,
  output logic            store_go
);

  logic       pend_q;
  logic [7:0] cmd_q;
  logic [7:0] idx_q;
  logic       in_range;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      cmd_q  <= '0;
      idx_q  <= '0;
    end else begin
      pend_q <= launch;
      if (launch) begin
        cmd_q <= launch_cmd;
        idx_q <= launch_idx;
      end
    end
  end

  assign in_range = ({24'd0, idx_q} < DEPTH);
  assign busy     = pend_q;
  assign tab_idx  = idx_q[IDXW-1:0];
  assign fetch_go = pend_q && in_range && (cmd_q == CMD_FETCH);
  assign store_go = pend_q && in_range && (cmd_q == CMD_STORE);

endmodule

// File: rtl/vlan_ind_store.sv
module vlan_ind_store
  import vlan_ind_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDXW = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IDXW-1:0] idx,
  input  logic            wr_go,
  input  vent_t           wr_entry,
  output vent_t           rd_entry
);

  vent_t cells [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cells[g] <= '0;
      end else if (wr_go && (idx == IDXW'(g))) begin
        cells[g] <= wr_entry;
      end
    end
  end

  assign rd_entry = cells[idx];

endmodule

// File: rtl/vlan_ind_table.sv
module vlan_ind_table
  import vlan_ind_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic       req_write,
  input  logic [7:0] req_addr,
  input  logic [7:0] req_wdata,
  output logic       rsp_valid,
  output logic [7:0] rsp_rdata,
  output logic       vlan_en
);

  localparam int IDXW = $clog2(DEPTH);

  logic            busy;
  logic            launch;
  logic [7:0]      launch_cmd;
  logic [7:0]      launch_idx;
  logic [IDXW-1:0] tab_idx;
  logic            fetch_go;
  logic            store_go;
  vent_t           stage;
  vent_t           rd_entry;

  vlan_ind_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .vlan_en    (vlan_en),
    .busy       (busy),
    .launch     (launch),
    .launch_cmd (launch_cmd),
    .launch_idx (launch_idx),
    .load_go    (fetch_go),
    .load_entry (rd_entry),
    .stage      (stage)
  );

  vlan_ind_seq #(.DEPTH(DEPTH)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .launch     (launch),
    .launch_cmd (launch_cmd),
    .launch_idx (launch_idx),
    .busy       (busy),
    .tab_idx    (tab_idx),
    .fetch_go   (fetch_go),
    .store_go   (store_go)
  );

  vlan_ind_store #(.DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx      (tab_idx),
    .wr_go    (store_go),
    .wr_entry (stage),
    .rd_entry (rd_entry)
  );

endmodule

// File: rtl/vlan_ind_table_chk.sv
module vlan_ind_table_chk
  import vlan_ind_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       req_write,
  input logic [7:0] req_addr,
  input logic [7:0] req_wdata,
  input logic       rsp_valid,
  input logic [7:0] rsp_rdata,
  input logic       vlan_en
);

  logic acc;
  assign acc = req_valid && req_ready;

  AST_STALL_AFTER_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write && req_addr == A_INDEX) |=> !req_ready); // R9

  AST_STALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> req_ready); // R9

  AST_RSP_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_write) |=> rsp_valid); // R9

  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write) |=> !rsp_valid); // R9

  AST_MODE_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write && req_addr == A_GLOBAL) |=> (vlan_en == $past(req_wdata[GLB_EN_BIT]))); // R2

  AST_MODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && req_write && req_addr == A_GLOBAL) |=> $stable(vlan_en)); // R2

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_write && !is_mapped(req_addr)) |=> (rsp_rdata == 8'h00)); // R10

endmodule

bind vlan_ind_table vlan_ind_table_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .req_addr  (req_addr),
  .req_wdata (req_wdata),
  .rsp_valid (rsp_valid),
  .rsp_rdata (rsp_rdata),
  .vlan_en   (vlan_en)
);

// File: tb/test_vlan_ind_table.sv
module test_vlan_ind_table;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic       req_write = 1'b0;
  logic [7:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic       rsp_valid;
  logic [7:0] rsp_rdata;
  logic       vlan_en;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // bench model
  logic [21:0] m_tab [16];
  logic [21:0] m_stage;
  logic [7:0]  m_cmd;
  logic [7:0]  m_idx;
  logic        m_en;

  always #10 clk = ~clk;

  vlan_ind_table i_vlan_ind_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .vlan_en   (vlan_en)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [7:0] a);
    case (a)
      8'h05:   return {m_en, 7'd0};
      8'h6E:   return m_cmd;
      8'h6F:   return m_idx;
      8'h76:   return {2'b00, m_stage[21:16]};
      8'h77:   return m_stage[15:8];
      8'h78:   return m_stage[7:0];
      default: return 8'h00;
    endcase
  endfunction

  task automatic xfer(input logic wr, input logic [7:0] a, input logic [7:0] d,
                      input string req, output logic [7:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    rd = rsp_rdata;
    chk({req, " R9 rsp_valid"}, {7'd0, rsp_valid}, {7'd0, !wr});
    if (wr && a == 8'h6F) chk("R9 ready low after index", {7'd0, req_ready}, 8'h00);
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    logic [7:0] dummy;
    xfer(1'b1, a, d, "write", dummy);
    case (a)
      8'h05: m_en = d[7];
      8'h6E: m_cmd = d;
      8'h6F: begin
        m_idx = d;
        if (d < 8'd16 && m_cmd == 8'h14) m_stage = m_tab[d[3:0]];
        else if (d < 8'd16 && m_cmd == 8'h04) m_tab[d[3:0]] = m_stage;
      end
      8'h76: m_stage[21:16] = d[5:0];
      8'h77: m_stage[15:8] = d;
      8'h78: m_stage[7:0] = d;
      default: ;
    endcase
  endtask

  task automatic rd_reg(input logic [7:0] a, input string req);
    logic [7:0] got;
    xfer(1'b0, a, 8'h00, req, got);
    chk(req, got, exp_read(a));
  endtask

  // fetch entry then read the staging bytes right away
  task automatic fetch_show(input logic [7:0] idx, input string req);
    wr_reg(8'h6E, 8'h14);
    wr_reg(8'h6F, idx);
    rd_reg(8'h76, req);
    rd_reg(8'h77, req);
    rd_reg(8'h78, req);
  endtask

  task automatic set_stage(input logic [7:0] hi, input logic [7:0] md, input logic [7:0] lo);
    wr_reg(8'h76, hi);
    wr_reg(8'h77, md);
    wr_reg(8'h78, lo);
  endtask

  initial begin
    logic [7:0] got;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) m_tab[i] = '0;
    m_stage = '0; m_cmd = '0; m_idx = '0; m_en = 1'b0;

    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    chk("R1 vlan_en after reset", {7'd0, vlan_en}, 8'h00);
    rd_reg(8'h76, "R1 staging hi reset");
    rd_reg(8'h78, "R1 staging lo reset");
    fetch_show(8'd7, "R1 entry 7 empty");
    fetch_show(8'd15, "R1 entry 15 empty");

    // R2 mode bit
    wr_reg(8'h05, 8'hFF);
    chk("R2 vlan_en set", {7'd0, vlan_en}, 8'h01);
    rd_reg(8'h05, "R2 global readback");
    wr_reg(8'h05, 8'h7F);
    chk("R2 vlan_en clear", {7'd0, vlan_en}, 8'h00);

    // R3/R4 store then fetch, packed layout
    set_stage(8'hF3, 8'hA7, 8'h5C);  // bits 7:6 dropped -> 0x33
    rd_reg(8'h76, "R8 staging hi keeps 5:0");
    wr_reg(8'h6E, 8'h04);
    wr_reg(8'h6F, 8'd5);
    set_stage(8'h00, 8'h00, 8'h00);
    wr_reg(8'h6E, 8'h14);
    wr_reg(8'h6F, 8'd5);
    xfer(1'b0, 8'h76, 8'h00, "R4", got);
    chk("R4 hi byte valid+ports", got, 8'h33);
    xfer(1'b0, 8'h77, 8'h00, "R4", got);
    chk("R4 mid byte fid+vid hi", got, 8'hA7);
    xfer(1'b0, 8'h78, 8'h00, "R4", got);
    chk("R3 low byte vid", got, 8'h5C);

    // R8 staging access leaves table alone
    wr_reg(8'h78, 8'h11);
    rd_reg(8'h78, "R8 staging readback");
    fetch_show(8'd5, "R8 entry 5 unchanged");

    // R6 out-of-range index
    set_stage(8'h2A, 8'hBB, 8'hCC);
    wr_reg(8'h6E, 8'h14);
    wr_reg(8'h6F, 8'd16);
    rd_reg(8'h76, "R6 fetch idx16 keeps staging");
    rd_reg(8'h77, "R6 fetch idx16 keeps staging");
    wr_reg(8'h6E, 8'h04);
    wr_reg(8'h6F, 8'd16);
    wr_reg(8'h6F, 8'd255);
    fetch_show(8'd0, "R6 entry 0 untouched by idx16");
    fetch_show(8'd15, "R6 entry 15 untouched by idx255");

    // R7 unknown command
    set_stage(8'h00, 8'h00, 8'h00);
    wr_reg(8'h6E, 8'h05);
    wr_reg(8'h6F, 8'd5);
    fetch_show(8'd5, "R7 unknown cmd no effect");

    // R5 zero store clears
    set_stage(8'h00, 8'h00, 8'h00);
    wr_reg(8'h6E, 8'h04);
    wr_reg(8'h6F, 8'd5);
    set_stage(8'h3F, 8'hFF, 8'hFF);
    wr_reg(8'h6E, 8'h14);
    wr_reg(8'h6F, 8'd5);
    xfer(1'b0, 8'h76, 8'h00, "R5", got);
    chk("R5 cleared entry invalid", got, 8'h00);

    // R10 unmapped
    wr_reg(8'h10, 8'hFF);
    rd_reg(8'h10, "R10 unmapped read zero");
    rd_reg(8'h6D, "R10 unmapped read zero");
    rd_reg(8'h05, "R10 unmapped write ignored");

    // random phase
    for (int n = 0; n < 600; n++) begin
      int sel;
      sel = int'($urandom % 10);
      case (sel)
        0, 1: wr_reg(8'h76 + 8'($urandom % 3), 8'($urandom));
        2: begin
          int c;
          c = int'($urandom % 4);
          wr_reg(8'h6E, (c == 0) ? 8'h14 : (c == 1) ? 8'h04 : (c == 2) ? 8'h14 : 8'($urandom));
        end
        3, 4: wr_reg(8'h6F, 8'($urandom % 20));
        5: wr_reg(8'h05, 8'($urandom));
        6: set_stage(8'h00, 8'h00, 8'h00);
        default: begin
          int k;
          logic [7:0] lst [8];
          lst = '{8'h05, 8'h6E, 8'h6F, 8'h76, 8'h77, 8'h78, 8'h10, 8'h79};
          k = int'($urandom % 8);
          rd_reg(lst[k], "R8 random read");
        end
      endcase
    end

    // final sweep of every entry
    for (int e = 0; e < 16; e++) fetch_show(8'(e), "R3 final entry sweep");
    chk("R2 final vlan_en", {7'd0, vlan_en}, {7'd0, m_en});

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule